// File: doc/BRIEF.md
# Justified Serial Audio Receiver

This block turns a two-channel serial audio stream into parallel 24-bit two's-complement sample pairs. The stream arrives on three lines: a bit clock, a word-select line that is high during the left-channel slot and low during the right-channel slot, and a serial data line. Data is sent most significant bit first and sampled on the rising bit-clock edge. One input chooses left-justified or right-justified framing. Each channel slot may be 24 or 32 bit clocks long, and the block needs no setting to tell the two apart.

All logic runs on one system clock. The three serial lines pass through synchronizers. A rising bit-clock edge is detected from the synchronized copy. In master mode an internal divider drives the bit clock and word select on the block's outputs and the receiver uses them. The master frame is fixed at 32 bit clocks per slot, or 64 per frame.

A finished left/right pair leaves on a valid/ready stream. When `out_valid` is high and `out_ready` is low, both the pair and `out_valid` stay frozen until the consumer takes the pair. A pair that completes while an earlier one is still waiting is discarded, because the serial source cannot be stalled. A pair is accepted on a clock edge where `out_valid` and `out_ready` are both high.

Top module: `jsr_top`

## Requirements
- R1: A slot sent with word select high is delivered on `out_left`, and a slot sent with word select low is delivered on `out_right`.
- R2: Bits are taken on the rising bit-clock edge, most significant first, as 24-bit two's complement. The full-scale values 0x7FFFFF and 0x800000 are recovered exactly.
- R3: With `fmt_rj`=0 (left-justified), the most significant bit is the bit in the first bit period after a word-select change. Any slot bits after the 24th have no effect on the output.
- R4: With `fmt_rj`=1 (right-justified), the least significant bit is the last bit before a word-select change. In a 32-clock slot the 8 leading bits have no effect on the output.
- R5: Slots of 24 and of 32 bit clocks are both received correctly in each framing mode, with no configuration input.
- R6: Exactly one pair is presented per complete left-then-right frame. It appears only after the word-select change that ends the right slot.
- R7: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_left` and `out_right` hold their values. Pairs that complete during the stall are dropped.
- R8: The slot in progress when the first word-select change after reset is seen is discarded. A right slot with no complete left slot before it produces no output.
- R9: With `master_en`=1, `sclk_o` has a period of 2*HALF_DIV system clocks. `lrclk_o` changes only on falling edges of `sclk_o` and stays at each level for 32 `sclk_o` rising edges. The receiver uses these generated clocks.
- R10: With `master_en`=0, `sclk_o` and `lrclk_o` are held at 0.
- R11: During and right after reset, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_rj | input | 1 | 0 = left-justified, 1 = right-justified |
| master_en | input | 1 | 1 = generate bit clock and word select internally |
| sclk_i | input | 1 | Serial bit clock from the source (slave mode) |
| lrclk_i | input | 1 | Word select from the source, high = left (slave mode) |
| sdata_i | input | 1 | Serial data |
| sclk_o | output | 1 | Generated bit clock (master mode) |
| lrclk_o | output | 1 | Generated word select (master mode) |
| out_valid | output | 1 | Sample pair available |
| out_ready | input | 1 | Consumer accepts the pair |
| out_left | output | 24 | Left sample, two's complement |
| out_right | output | 24 | Right sample, two's complement |

## Verification
The bench sends frames in both framings at both slot lengths. Unused slot bits carry random data, so a receiver that does not mask them, or that places the word one bit off, produces wrong samples. Full-scale positive and negative words catch sign or bit-order errors. A start-up sequence with a partial left slot followed by a right slot with no left checks that a receiver which trusts its first slot emits a spurious pair. A long stall checks that a design which overwrites the held pair, or lets valid drop, is caught. In master mode the bench measures the generated clock period and the slot length, so a divider or slot counter that is off by one shows up.

// File: rtl/jsr_pkg.sv
package jsr_pkg;
  localparam int unsigned SAMPLE_W = 24;
  typedef logic [SAMPLE_W-1:0] sample_t;
  typedef enum logic {FMT_LEFT_JUST = 1'b0, FMT_RIGHT_JUST = 1'b1} fmt_e;
  typedef struct packed {
    sample_t left;
    sample_t right;
  } pair_t;
endpackage

// File: rtl/jsr_sync.sv
module jsr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_raw,
  input  logic ws_raw,
  input  logic sd_raw,
  output logic ws_s,
  output logic sd_s,
  output logic bit_stb
);
  localparam int unsigned NSIG = 3;
  logic [NSIG-1:0] chain [STAGES];
  logic bclk_prev;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= {bclk_raw, ws_raw, sd_raw};
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bclk_prev <= 1'b0;
    else        bclk_prev <= chain[STAGES-1][2];
  end

  assign ws_s    = chain[STAGES-1][1];
  assign sd_s    = chain[STAGES-1][0];
  assign bit_stb = chain[STAGES-1][2] & ~bclk_prev;
endmodule

// File: rtl/jsr_clkgen.sv
module jsr_clkgen #(
  parameter int unsigned HALF_DIV = 4,
  parameter int unsigned SLOT_LEN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic sclk_g,
  output logic ws_g
);
  localparam int unsigned DIV_W  = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int unsigned SLOT_W = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1;

  logic [DIV_W-1:0]  div_q;
  logic [SLOT_W-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      div_q  <= '0;
      slot_q <= '0;
      sclk_g <= 1'b0;
      ws_g   <= 1'b0;
    end else if (div_q == DIV_W'(HALF_DIV - 1)) begin
      div_q  <= '0;
      sclk_g <= ~sclk_g;
      if (sclk_g) begin
        if (slot_q == SLOT_W'(SLOT_LEN - 1)) begin
          slot_q <= '0;
          ws_g   <= ~ws_g;
        end else begin
          slot_q <= slot_q + 1'b1;
        end
      end
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  // R9
  ws_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && (ws_g != $past(ws_g))) |-> ($past(sclk_g) && !sclk_g));

  // R9
  sclk_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $rose(sclk_g)) |=> sclk_g);
endmodule

// File: rtl/jsr_deser.sv
module jsr_deser
  import jsr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  fmt_e  fmt,
  input  logic  bit_stb,
  input  logic  ws_bit,
  input  logic  sd_bit,
  output logic  pair_v,
  output pair_t pair_q
);
  localparam int unsigned CNT_W = $clog2(SAMPLE_W + 1);

  logic             ws_q, have_q, started_q, have_left_q;
  sample_t          sh_q, left_q;
  logic [CNT_W-1:0] cnt_q;
  logic             slot_edge;
  sample_t          sh_next;

  assign slot_edge = bit_stb && have_q && (ws_bit != ws_q);
  assign sh_next   = {sh_q[SAMPLE_W-2:0], sd_bit};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ws_q        <= 1'b0;
      have_q      <= 1'b0;
      started_q   <= 1'b0;
      have_left_q <= 1'b0;
      sh_q        <= '0;
      left_q      <= '0;
      cnt_q       <= CNT_W'(SAMPLE_W);
      pair_v      <= 1'b0;
      pair_q      <= '0;
    end else begin
      pair_v <= 1'b0;
      if (bit_stb) begin
        have_q <= 1'b1;
        ws_q   <= ws_bit;
        if (slot_edge) begin
          started_q <= 1'b1;
          if (started_q) begin
            if (ws_q) begin
              left_q      <= sh_q;
              have_left_q <= 1'b1;
            end else if (have_left_q) begin
              pair_q      <= '{left: left_q, right: sh_q};
              pair_v      <= 1'b1;
              have_left_q <= 1'b0;
            end
          end
          if (fmt == FMT_LEFT_JUST) begin
            sh_q  <= {{(SAMPLE_W-1){1'b0}}, sd_bit};
            cnt_q <= CNT_W'(1);
          end else begin
            sh_q <= sh_next;
          end
        end else if (fmt == FMT_RIGHT_JUST) begin
          sh_q <= sh_next;
        end else if (cnt_q < CNT_W'(SAMPLE_W)) begin
          sh_q  <= sh_next;
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R6
  pair_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_v |=> !pair_v);

  // R6
  pair_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_v |-> $past(bit_stb));
endmodule

// File: rtl/jsr_outq.sv
module jsr_outq
  import jsr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pair_v,
  input  pair_t pair_d,
  output logic  out_valid,
  input  logic  out_ready,
  output pair_t out_pair
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pair  <= '0;
    end else if (pair_v && (!out_valid || out_ready)) begin
      out_valid <= 1'b1;
      out_pair  <= pair_d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pair)));

  // R6
  valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(pair_v));
endmodule

// File: rtl/jsr_top.sv
module jsr_top
  import jsr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HALF_DIV    = 4,
  parameter int unsigned MASTER_SLOT = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fmt_rj,
  input  logic                master_en,
  input  logic                sclk_i,
  input  logic                lrclk_i,
  input  logic                sdata_i,
  output logic                sclk_o,
  output logic                lrclk_o,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_left,
  output logic [SAMPLE_W-1:0] out_right
);
  logic  sclk_gen, ws_gen, bclk_sel, ws_sel;
  logic  ws_s, sd_s, bit_stb;
  logic  pair_v;
  pair_t pair_d, pair_o;
  fmt_e  fmt;

  assign fmt = fmt_e'(fmt_rj);

  jsr_clkgen #(.HALF_DIV(HALF_DIV), .SLOT_LEN(MASTER_SLOT)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .en(master_en),
    .sclk_g(sclk_gen), .ws_g(ws_gen)
  );

  assign bclk_sel = master_en ? sclk_gen : sclk_i;
  assign ws_sel   = master_en ? ws_gen   : lrclk_i;
  assign sclk_o   = sclk_gen;
  assign lrclk_o  = ws_gen;

  jsr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .bclk_raw(bclk_sel), .ws_raw(ws_sel), .sd_raw(sdata_i),
    .ws_s(ws_s), .sd_s(sd_s), .bit_stb(bit_stb)
  );

  jsr_deser u_deser (
    .clk(clk), .rst_n(rst_n), .fmt(fmt),
    .bit_stb(bit_stb), .ws_bit(ws_s), .sd_bit(sd_s),
    .pair_v(pair_v), .pair_q(pair_d)
  );

  jsr_outq u_outq (
    .clk(clk), .rst_n(rst_n), .pair_v(pair_v), .pair_d(pair_d),
    .out_valid(out_valid), .out_ready(out_ready), .out_pair(pair_o)
  );

  assign out_left  = pair_o.left;
  assign out_right = pair_o.right;

  // R10
  idle_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_en && $past(!master_en)) |-> (!sclk_o && !lrclk_o));

  // R11
  reset_valid_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> !out_valid);
endmodule

// File: tb/sim_jsr_top.sv
module sim_jsr_top;
  localparam int SH = 3;
  localparam int HALF_DIV = 4;

  logic clk = 1'b0, rst_n = 1'b0, fmt_rj = 1'b0, master_en = 1'b0;
  logic sclk_i = 1'b0, lrclk_i = 1'b0, sdata_i = 1'b0, out_ready = 1'b1;
  logic sclk_o, lrclk_o, out_valid;
  logic [23:0] out_left, out_right;

  int n_tests = 0, n_fail = 0;
  logic [23:0] ql[$], qr[$];
  string tag = "R11";
  logic hold_prev = 1'b0;
  logic [23:0] pl, pr;

  always #2 clk = ~clk;

  jsr_top u0 (
    .clk(clk), .rst_n(rst_n), .fmt_rj(fmt_rj), .master_en(master_en),
    .sclk_i(sclk_i), .lrclk_i(lrclk_i), .sdata_i(sdata_i),
    .sclk_o(sclk_o), .lrclk_o(lrclk_o), .out_valid(out_valid),
    .out_ready(out_ready), .out_left(out_left), .out_right(out_right)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [47:0] act, input logic [47:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Reference comparison on every clock
  always @(negedge clk) begin
    if (!rst_n) hold_prev = 1'b0;
    else begin
      if (hold_prev)
        chk(out_valid && out_left == pl && out_right == pr, "R7", "held pair",
            {out_left, out_right}, {pl, pr});
      if (out_valid && out_ready) begin
        if (ql.size() == 0)
          chk(1'b0, "R6/R8", "unexpected pair", {out_left, out_right}, 48'h0);
        else begin
          logic [23:0] el, er;
          el = ql.pop_front();
          er = qr.pop_front();
          chk(out_left == el && out_right == er, tag, "R1/R2 pair",
              {out_left, out_right}, {el, er});
        end
      end
      hold_prev = out_valid && !out_ready;
      pl = out_left;
      pr = out_right;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic rj, input logic mst);
    tick();
    rst_n = 1'b0;
    fmt_rj = rj; master_en = mst;
    sclk_i = 1'b0; lrclk_i = 1'b0; sdata_i = 1'b0; out_ready = 1'b1;
    ql.delete(); qr.delete();
    repeat (5) tick();
    rst_n = 1'b1;
    repeat (3) tick();
  endtask

  function automatic logic slot_bit(input logic [23:0] w, input int i, input int slot);
    int off;
    off = fmt_rj ? slot - 24 : 0;
    if (i < off || i >= off + 24) return 1'($urandom);
    return w[23 - (i - off)];
  endfunction

  task automatic sbit(input logic ws, input logic d);
    sclk_i = 1'b0; lrclk_i = ws; sdata_i = d;
    repeat (SH) tick();
    sclk_i = 1'b1;
    repeat (SH) tick();
  endtask

  task automatic sframe(input logic [23:0] l, input logic [23:0] r,
                        input int slot, input bit push);
    for (int i = 0; i < slot; i++) sbit(1'b1, slot_bit(l, i, slot));
    for (int i = 0; i < slot; i++) sbit(1'b0, slot_bit(r, i, slot));
    if (push) begin ql.push_back(l); qr.push_back(r); end
  endtask

  task automatic drain(input string req);
    repeat (40) tick();
    chk(ql.size() == 0, req, "all pairs delivered", 48'(ql.size()), 48'h0);
  endtask

  task automatic run_slave(input logic rj, input int slot, input string t);
    do_reset(rj, 1'b0);
    tag = t;
    for (int i = 0; i < 5; i++) sbit(1'b0, 1'($urandom));
    sframe(24'h7FFFFF, 24'h800000, slot, 1);
    sframe(24'h800000, 24'h7FFFFF, slot, 1);
    for (int f = 0; f < 5; f++) sframe(24'($urandom), 24'($urandom), slot, 1);
    for (int i = 0; i < 3; i++) sbit(1'b1, 1'($urandom));
    drain({t, " R6"});
  endtask

  task automatic measure();
    realtime t0;
    int n;
    @(posedge sclk_o); t0 = $realtime;
    @(posedge sclk_o);
    chk(($realtime - t0) == 2.0 * HALF_DIV * 4.0, "R9", "sclk_o period ns",
        48'(int'($realtime - t0)), 48'(2 * HALF_DIV * 4));
    @(posedge lrclk_o);
    n = 0;
    forever begin
      @(posedge sclk_o or negedge lrclk_o);
      if (!lrclk_o) break;
      n++;
    end
    chk(n == 32, "R9", "bit clocks per slot", 48'(n), 48'd32);
  endtask

  task automatic mframes(input int nf);
    logic [23:0] w [2];
    @(posedge lrclk_o);
    #1;
    for (int f = 0; f < nf; f++) begin
      w[0] = (f == 0) ? 24'h800000 : 24'($urandom);
      w[1] = (f == 0) ? 24'h7FFFFF : 24'($urandom);
      for (int ch = 0; ch < 2; ch++)
        for (int i = 0; i < 32; i++) begin
          if (!(f == 0 && ch == 0 && i == 0)) begin @(negedge sclk_o); #1; end
          sdata_i = slot_bit(w[ch], i, 32);
        end
      ql.push_back(w[0]); qr.push_back(w[1]);
    end
    @(posedge lrclk_o);
    repeat (3) @(negedge sclk_o);
    #1;
  endtask

  task automatic run_master(input logic rj, input string t);
    do_reset(rj, 1'b1);
    tag = t;
    fork
      measure();
      mframes(5);
    join
    drain({t, " R9"});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", "run timed out", 48'h0, 48'h0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset(1'b0, 1'b0);
    // R11 and R10 after reset
    chk(out_valid == 1'b0, "R11", "out_valid after reset", 48'(out_valid), 48'h0);
    chk(sclk_o == 1'b0 && lrclk_o == 1'b0, "R10", "idle master outputs",
        {46'h0, sclk_o, lrclk_o}, 48'h0);

    run_slave(1'b0, 32, "R3/R5 lj32");
    run_slave(1'b0, 24, "R3/R5 lj24");
    run_slave(1'b1, 32, "R4/R5 rj32");
    run_slave(1'b1, 24, "R4/R5 rj24");
    chk(sclk_o == 1'b0 && lrclk_o == 1'b0, "R10", "slave leaves outputs low",
        {46'h0, sclk_o, lrclk_o}, 48'h0);

    // R8: partial left slot, then a right slot with no left
    do_reset(1'b0, 1'b0);
    tag = "R8";
    for (int i = 0; i < 10; i++) sbit(1'b1, 1'($urandom));
    for (int i = 0; i < 32; i++) sbit(1'b0, 1'($urandom));
    sframe(24'h123456, 24'hABCDEF, 32, 1);
    sframe(24'($urandom), 24'($urandom), 32, 1);
    for (int i = 0; i < 3; i++) sbit(1'b1, 1'b0);
    drain("R8");

    // R7: stall across three frames
    do_reset(1'b1, 1'b0);
    tag = "R7";
    out_ready = 1'b0;
    for (int i = 0; i < 4; i++) sbit(1'b0, 1'b0);
    sframe(24'h00F00D, 24'hFACADE, 32, 1);
    sframe(24'h111111, 24'h222222, 32, 0);
    sframe(24'h333333, 24'h444444, 32, 0);
    for (int i = 0; i < 3; i++) sbit(1'b1, 1'b0);
    repeat (20) tick();
    chk(out_valid && out_left == 24'h00F00D && out_right == 24'hFACADE, "R7",
        "first pair kept during stall", {out_left, out_right}, 48'h00F00DFACADE);
    out_ready = 1'b1;
    repeat (3) tick();
    chk(out_valid == 1'b0, "R7", "dropped pairs never appear", 48'(out_valid), 48'h0);
    drain("R7");

    run_master(1'b0, "R9 lj");
    run_master(1'b1, "R9/R4 rj");

    do_reset(1'b0, 1'b0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule